// File: doc/BRIEF.md
# Signed-Magnitude Sequential Divider with Overflow Check

This block divides a double-length signed-magnitude dividend by a single-length signed-magnitude divisor. Every word is `W` bits wide. The most significant bit of a word is its sign, and the other `W-1` bits are its magnitude. The dividend arrives as one sign bit and two magnitude halves, a high half and a low half. Together the two halves form a `2(W-1)`-bit magnitude.

After a one-cycle start pulse, the block first makes a trial subtraction of the divisor magnitude from the high half. The carry out of that subtraction shows whether the quotient would fit in `W-1` bits. If it would not fit, the block reports divide overflow and stops. Otherwise it runs `W-1` non-restoring steps. In each step the partial remainder and quotient registers shift left together, and the block then adds or subtracts the divisor according to the sign bit that was present before the shift. One correction cycle follows, which restores a negative final remainder. The quotient sign is the XOR of the two operand signs. The remainder takes the dividend's sign.

The outputs are registered. They change only in the cycle in which `done` pulses, and they hold their values until the next completion.

Top module: `sm_divider`

## Requirements
- R1: While reset is held and after it is released, `done`, `ovf`, `quo` and `rem` are all zero.
- R2: When the high-half magnitude is greater than or equal to the divisor magnitude (`dvs[W-2:0]`), the block raises `ovf` together with `done`, and both `quo` and `rem` are zero.
- R3: A divisor magnitude of zero always gives overflow, whatever the dividend is, including a zero dividend.
- R4: Without overflow, `quo[W-2:0]` equals floor((hi·2^(W-1) + lo) / divisor magnitude), and `rem[W-2:0]` equals the matching modulus.
- R5: Without overflow, `quo[W-1]` equals `dvd_sign` XOR `dvs[W-1]`, and `rem[W-1]` equals `dvd_sign`. This holds even when the magnitudes are zero.
- R6: Counting from the rising edge that accepts `start`, `done` goes high after the 1st following edge on overflow. Otherwise it goes high after the (W+1)th following edge.
- R7: `done` is high for exactly one cycle. `quo`, `rem` and `ovf` keep their values until the next `done`.
- R8: A `start` pulse that arrives while an operation is in progress is ignored. The running operation's result and timing do not change, and no extra `done` appears.
- R9: When the partial remainder is negative after the last step, the divisor is added back once without a shift. With W=5, a dividend of -181 (sign 1, hi 1011, lo 0101) and a divisor of +14 (01110) give `quo` = 11100 (-12) and `rem` = 11101 (-13).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Synchronous reset, active low |
| start | input | 1 | Single-cycle request to begin a division |
| dvd_sign | input | 1 | Dividend sign (1 = negative) |
| dvd_hi | input | W-1 | High half of the dividend magnitude |
| dvd_lo | input | W-1 | Low half of the dividend magnitude |
| dvs | input | W | Divisor: sign in the MSB, magnitude below it |
| quo | output | W | Quotient: sign in the MSB, magnitude below it |
| rem | output | W | Remainder: sign in the MSB, magnitude below it |
| ovf | output | 1 | Divide overflow, valid with `done` |
| done | output | 1 | One-cycle completion pulse |

## Verification
The hardest path to reach from the ports is the final correction cycle. It only does work when the last add or subtract leaves a negative partial remainder, and no single port shows that condition. The stimulus reaches it through the worked W=5 case, which is known to need the restore, and through a few hundred random operand sets with the high half kept below the divisor, so both outcomes of the last step occur many times. Overflow is reached at its exact boundary (high half equal to the divisor), and a second `start` is injected in the middle of a running operation.

// File: rtl/sm_div_pkg.sv
// Shared definitions for the signed-magnitude divider.
// Assumes nothing beyond the types declared here.
package sm_div_pkg;

    // Controller phases: waiting, overflow trial, shift/op loop, remainder fix-up
    typedef enum logic [1:0] {
        ST_IDLE  = 2'd0,
        ST_CHECK = 2'd1,
        ST_RUN   = 2'd2,
        ST_FIX   = 2'd3
    } div_state_e;

endpackage

// File: rtl/sm_div_addsub.sv
// Ripple add/subtract of two WIDTH-bit words, modulo 2^WIDTH.
// When sub is high, b is inverted and a carry-in of one is applied, so sum = a - b.
// Assumes WIDTH >= 2. No carry out is produced.
module sm_div_addsub #(
    parameter int WIDTH = 8
) (
    input  logic [WIDTH-1:0] a,
    input  logic [WIDTH-1:0] b,
    input  logic             sub,
    output logic [WIDTH-1:0] sum
);

    logic [WIDTH-1:0] carry;

    // carry into bit 0 is the subtract select
    assign carry[0] = sub;

    for (genvar g = 0; g < WIDTH; g++) begin : g_bit
        logic b_eff;
        // conditional inversion of the second operand
        assign b_eff  = b[g] ^ sub;
        // sum bit of this cell
        assign sum[g] = a[g] ^ b_eff ^ carry[g];
        if (g < WIDTH - 1) begin : g_carry
            // carry into the next cell
            assign carry[g+1] = (a[g] & b_eff) | (carry[g] & (a[g] ^ b_eff));
        end
    end

endmodule

// File: rtl/sm_div_ovf_chk.sv
// Trial subtraction hi - dmag, keeping only the carry chain.
// The output is high when hi >= dmag, which means the quotient would not fit in MAG bits.
// A zero dmag always gives a high output.
// Assumes MAG >= 1.
module sm_div_ovf_chk #(
    parameter int MAG = 7
) (
    input  logic [MAG-1:0] hi,
    input  logic [MAG-1:0] dmag,
    output logic           ovf_hit
);

    logic [MAG:0] c;

    // subtract: carry-in of one, inverted divisor
    assign c[0] = 1'b1;

    for (genvar g = 0; g < MAG; g++) begin : g_cell
        logic nd;
        // one's complement of the divisor bit
        assign nd     = ~dmag[g];
        // carry propagate/generate
        assign c[g+1] = (hi[g] & nd) | (c[g] & (hi[g] ^ nd));
    end

    // carry out of the top cell is the overflow verdict
    assign ovf_hit = c[MAG];

endmodule

// File: rtl/sm_div_step.sv
// One non-restoring iteration, or the final remainder fix-up.
// Iteration (restore=0): shift {sa,bq} left by one, then subtract the divisor if
// the old sign bit sa[W-1] is 0 and add it if that bit is 1. The inverted result
// sign becomes the new quotient bit.
// Fix-up (restore=1): no shift; the divisor is added only when sa is negative.
// Assumes W >= 3 and that the partial remainder stays within [-dmag, dmag).
module sm_div_step #(
    parameter int W = 8
) (
    input  logic         restore,
    input  logic [W-1:0] sa,
    input  logic [W-2:0] bq,
    input  logic [W-2:0] dmag,
    output logic [W-1:0] sa_next,
    output logic [W-2:0] b_next
);

    localparam int M = W - 1;

    logic [W-1:0] opa;
    logic         do_sub;
    logic [W-1:0] sum;

    // first operand: shifted remainder in a step, unshifted during the fix-up
    assign opa    = restore ? sa : {sa[M-1:0], bq[M-1]};
    // subtract only in a step whose previous remainder was non-negative
    assign do_sub = !restore && !sa[M];

    sm_div_addsub #(.WIDTH(W)) u_addsub (
        .a   (opa),
        .b   ({1'b0, dmag}),
        .sub (do_sub),
        .sum (sum)
    );

    // new remainder and quotient register contents
    always_comb begin
        if (restore) begin
            sa_next = sa[M] ? sum : sa;
            b_next  = bq;
        end else begin
            sa_next = sum;
            b_next  = {bq[M-2:0], ~sum[M]};
        end
    end

endmodule

// File: rtl/sm_divider.sv
// Signed-magnitude sequential divider with an up-front overflow check.
// A start pulse in idle latches the operands. The next cycle makes the overflow trial.
// Without overflow there follow W-1 iterations and one fix-up cycle, and done then
// pulses with a registered quotient and remainder.
// Assumes W >= 3. start is ignored outside idle.
module sm_divider
    import sm_div_pkg::*;
#(
    parameter int W = 8
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         start,
    input  logic         dvd_sign,
    input  logic [W-2:0] dvd_hi,
    input  logic [W-2:0] dvd_lo,
    input  logic [W-1:0] dvs,
    output logic [W-1:0] quo,
    output logic [W-1:0] rem,
    output logic         ovf,
    output logic         done
);

    localparam int M  = W - 1;
    localparam int CW = $clog2(M + 1);

    div_state_e    state;
    logic          sign_q;
    logic [W-1:0]  dvs_q;
    logic [W-1:0]  sa_q;
    logic [M-1:0]  b_q;
    logic [CW-1:0] cnt_q;

    logic          ovf_hit;
    logic [W-1:0]  sa_nx;
    logic [M-1:0]  b_nx;

    sm_div_ovf_chk #(.MAG(M)) u_ovf (
        .hi      (sa_q[M-1:0]),
        .dmag    (dvs_q[M-1:0]),
        .ovf_hit (ovf_hit)
    );

    sm_div_step #(.W(W)) u_step (
        .restore (state == ST_FIX),
        .sa      (sa_q),
        .bq      (b_q),
        .dmag    (dvs_q[M-1:0]),
        .sa_next (sa_nx),
        .b_next  (b_nx)
    );

    // sequencing, working registers and result registers
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state  <= ST_IDLE;
            sign_q <= 1'b0;
            dvs_q  <= '0;
            sa_q   <= '0;
            b_q    <= '0;
            cnt_q  <= '0;
            quo    <= '0;
            rem    <= '0;
            ovf    <= 1'b0;
            done   <= 1'b0;
        end else begin
            done <= 1'b0;
            case (state)
                ST_IDLE: begin
                    if (start) begin
                        sign_q <= dvd_sign;
                        dvs_q  <= dvs;
                        sa_q   <= {1'b0, dvd_hi};
                        b_q    <= dvd_lo;
                        cnt_q  <= '0;
                        state  <= ST_CHECK;
                    end
                end
                ST_CHECK: begin
                    if (ovf_hit) begin
                        ovf   <= 1'b1;
                        quo   <= '0;
                        rem   <= '0;
                        done  <= 1'b1;
                        state <= ST_IDLE;
                    end else begin
                        state <= ST_RUN;
                    end
                end
                ST_RUN: begin
                    sa_q  <= sa_nx;
                    b_q   <= b_nx;
                    cnt_q <= cnt_q + 1'b1;
                    if (cnt_q == CW'(M - 1)) begin
                        state <= ST_FIX;
                    end
                end
                ST_FIX: begin
                    sa_q  <= sa_nx;
                    quo   <= {sign_q ^ dvs_q[M], b_nx};
                    rem   <= {sign_q, sa_nx[M-1:0]};
                    ovf   <= 1'b0;
                    done  <= 1'b1;
                    state <= ST_IDLE;
                end
                default: state <= ST_IDLE;
            endcase
        end
    end

endmodule

// File: rtl/sm_div_chk.sv
// Property checker for sm_divider, bound to every instance.
// Assumes dvs_q and sign_q are the operands latched at the accepting edge.
module sm_div_chk #(
    parameter int W = 8
) (
    input logic         clk,
    input logic         rst_n,
    input logic         done,
    input logic         ovf,
    input logic [W-1:0] quo,
    input logic [W-1:0] rem,
    input logic [W-1:0] dvs_q,
    input logic         sign_q
);

    // R2
    ovf_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (done && ovf) |-> (quo == '0 && rem == '0));

    // R3
    zero_div_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (done && dvs_q[W-2:0] == '0) |-> ovf);

    // R4
    rem_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (done && !ovf) |-> (rem[W-2:0] < dvs_q[W-2:0]));

    // R5
    sign_rule_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (done && !ovf) |-> (rem[W-1] == sign_q && quo[W-1] == (sign_q ^ dvs_q[W-1])));

    // R7
    done_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);

    // R7
    hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !done |-> ($stable(quo) && $stable(rem) && $stable(ovf)));

endmodule

bind sm_divider sm_div_chk #(.W(W)) u_chk (
    .clk    (clk),
    .rst_n  (rst_n),
    .done   (done),
    .ovf    (ovf),
    .quo    (quo),
    .rem    (rem),
    .dvs_q  (dvs_q),
    .sign_q (sign_q)
);

// File: tb/test_sm_divider.sv
// Scoreboard bench: the driver queues expected results, the monitor pops them on done.
module test_sm_divider;

    localparam int W = 5;
    localparam int M = W - 1;

    typedef struct packed {
        logic [W-1:0] quo;
        logic [W-1:0] rem;
        logic         ovf;
        int           lat;
        int           t0;
        int           req;
    } exp_t;

    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic         start = 1'b0;
    logic         dvd_sign = 1'b0;
    logic [M-1:0] dvd_hi = '0;
    logic [M-1:0] dvd_lo = '0;
    logic [W-1:0] dvs = '0;
    logic [W-1:0] quo;
    logic [W-1:0] rem;
    logic         ovf;
    logic         done;

    int   n_chk = 0;
    int   n_bad = 0;
    int   cyc = 0;
    int   pending = 0;
    bit   finished = 1'b0;
    exp_t sb[$];

    sm_divider #(.W(W)) i_sm_divider (
        .clk(clk), .rst_n(rst_n), .start(start), .dvd_sign(dvd_sign),
        .dvd_hi(dvd_hi), .dvd_lo(dvd_lo), .dvs(dvs),
        .quo(quo), .rem(rem), .ovf(ovf), .done(done)
    );

    always #2 clk = ~clk;

    always @(posedge clk) cyc <= cyc + 1;

    task automatic check(input bit ok, input int req, input string what,
                         input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_bad++;
            $display("FAIL R%0d %s: actual %0h expected %0h", req, what, act, exp);
        end
    endtask

    // monitor: compare each completion with the head of the scoreboard
    always @(negedge clk) begin
        if (rst_n && done) begin
            if (pending == 0) begin
                // R8: no completion may appear without a queued request
                check(1'b0, 8, "spurious done", 1, 0);
            end else begin
                exp_t e;
                e = sb.pop_front();
                pending--;
                check(quo == e.quo, e.req, "quotient", int'(quo), int'(e.quo));
                check(rem == e.rem, e.req, "remainder", int'(rem), int'(e.rem));
                check(ovf == e.ovf, e.req, "overflow", int'(ovf), int'(e.ovf));
                // R6 latency from the accepting edge
                check(cyc - e.t0 == e.lat + 1, 6, "latency", cyc - e.t0, e.lat + 1);
            end
        end
    end

    task automatic run_op(input logic s, input logic [M-1:0] a, input logic [M-1:0] b,
                          input logic [W-1:0] d, input int req, input bit disturb);
        exp_t    e;
        longint  dd;
        longint  mag;
        mag = longint'(d[M-1:0]);
        if (longint'(a) >= mag) begin
            e.quo = '0;
            e.rem = '0;
            e.ovf = 1'b1;
            e.lat = 1;
        end else begin
            dd    = (longint'(a) << M) + longint'(b);
            e.quo = {s ^ d[W-1], M'(dd / mag)};
            e.rem = {s, M'(dd % mag)};
            e.ovf = 1'b0;
            e.lat = W + 1;
        end
        e.req = req;
        @(negedge clk);
        dvd_sign = s; dvd_hi = a; dvd_lo = b; dvs = d; start = 1'b1;
        e.t0 = cyc;
        sb.push_back(e);
        pending++;
        @(negedge clk);
        start = 1'b0;
        if (disturb) begin
            // R8: a second request in the middle of the run
            repeat (2) @(negedge clk);
            dvd_sign = ~s; dvd_hi = '0; dvd_lo = ~b; dvs = {1'b0, {(M-1){1'b0}}, 1'b1};
            start = 1'b1;
            @(negedge clk);
            start = 1'b0;
        end
        while (pending != 0) @(negedge clk);
        // R7: pulse ends and results hold
        repeat (3) begin
            @(negedge clk);
            check(done == 1'b0, 7, "done pulse width", int'(done), 0);
            check(quo == e.quo && rem == e.rem && ovf == e.ovf, 7, "held result",
                  int'({quo, rem, ovf}), int'({e.quo, e.rem, e.ovf}));
        end
    endtask

    initial begin
        repeat (4) @(negedge clk);
        // R1 during reset
        check(done == 0 && ovf == 0 && quo == 0 && rem == 0, 1, "reset outputs",
              int'({done, ovf, quo, rem}), 0);
        rst_n = 1'b1;
        repeat (2) @(negedge clk);
        // R1 after release
        check(done == 0 && ovf == 0 && quo == 0 && rem == 0, 1, "idle outputs",
              int'({done, ovf, quo, rem}), 0);

        // R9 worked case: -181 / +14 -> -12 rem -13
        run_op(1'b1, 4'b1011, 4'b0101, 5'b01110, 9, 1'b0);
        check(quo == 5'b11100 && rem == 5'b11101, 9, "worked case",
              int'({quo, rem}), int'({5'b11100, 5'b11101}));

        // R2 boundary: hi equal to divisor, and hi above it
        run_op(1'b0, 4'd7, 4'd3, 5'b00111, 2, 1'b0);
        run_op(1'b1, 4'd15, 4'd15, 5'b10011, 2, 1'b0);

        // R3 zero divisor, positive and negative zero, zero dividend
        run_op(1'b0, 4'd0, 4'd0, 5'b00000, 3, 1'b0);
        run_op(1'b1, 4'd0, 4'd9, 5'b10000, 3, 1'b0);

        // R5 zero dividend keeps the sign rules
        run_op(1'b0, 4'd0, 4'd0, 5'b10011, 5, 1'b0);
        run_op(1'b1, 4'd0, 4'd0, 5'b10001, 5, 1'b0);

        // R4 largest quotient: hi one below divisor, lo all ones
        run_op(1'b0, 4'd14, 4'd15, 5'b01111, 4, 1'b0);
        run_op(1'b0, 4'd0, 4'd15, 5'b00001, 4, 1'b0);

        // R8 start while busy
        run_op(1'b1, 4'd5, 4'd10, 5'b01001, 8, 1'b1);
        run_op(1'b0, 4'd2, 4'd7, 5'b10110, 8, 1'b1);

        // R4 random operands without overflow; R5 random signs
        for (int i = 0; i < 300; i++) begin
            logic [M-1:0] dm;
            logic [M-1:0] ah;
            dm = M'($urandom_range(1, (1 << M) - 1));
            ah = M'($urandom_range(0, int'(dm) - 1));
            run_op(1'($urandom), ah, M'($urandom), {1'($urandom), dm},
                   (i % 2 == 0) ? 4 : 5, 1'b0);
        end

        // R2 random operands with overflow
        for (int i = 0; i < 40; i++) begin
            logic [M-1:0] dm;
            dm = M'($urandom_range(0, (1 << M) - 1));
            run_op(1'($urandom), M'($urandom_range(int'(dm), (1 << M) - 1)), M'($urandom),
                   {1'($urandom), dm}, 2, 1'b0);
        end

        repeat (4) @(negedge clk);
        check(pending == 0, 8, "queue drained", pending, 0);
        if (!finished) begin
            finished = 1'b1;
            $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
            $finish;
        end
    end

    // watchdog
    initial begin
        repeat (150000) @(posedge clk);
        if (!finished) begin
            finished = 1'b1;
            n_chk++;
            n_bad++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
            $finish;
        end
    end

endmodule